// File: doc/BRIEF.md
# Address Window Register Bank

This block holds a pair of 64-bit window-configuration entries and an index register that picks which entry a software-style access touches. Writes are split into a low-half port and a high-half port, each with its own bit mask, so a narrow host can build a full entry in two steps. A small control register carries a cell-spacing grain field and a cell count that is loaded from a parameter at reset.

Entry 0 drives a live address window. Its fields give a base address, a power-of-two size and an enable. A registered decoder compares each incoming bus address against that window. It reports a hit, the offset inside the window, the index of the storage cell the offset falls in, and whether that cell index lies beyond the configured count. Entry 1 is storage only. Any write to entry 0 changes the window on the following cycle.

Top module: `addr_window_bank`

## Requirements
- R1: After reset the index is 0 and entry 0 reads 0x22, which is a disabled window with size log2 of 17 and a base of 0. Entry 1 reads 0, the grain is 0, and the control word reads NUM_CELLS in bits 15:8 and the grain in bits 2:0.
- R2: A write with cfg_sel=0 stores cfg_wdata[5:0] as the index, and a read with cfg_sel=0 returns it zero-extended.
- R3: A write with cfg_sel=1 stores cfg_wdata AND 0x00000FFFFFFFF03F into the selected entry.
- R4: A write with cfg_sel=2 places cfg_wdata[11:0] in bits 43:32 of the selected entry and keeps bits 31:0 of that entry unchanged.
- R5: When the index is 2 or more, entry writes (cfg_sel=1 or 2) change no entry, and entry reads (cfg_sel=1 or 2) return 0.
- R6: win_base equals entry 0 bits 47:13 placed at bits 51:17, win_size_log2 equals entry 0 bits 5:1, and win_en equals entry 0 bit 0. All three follow a write to entry 0 on the next cycle.
- R7: Writes to entry 1 leave win_base, win_size_log2 and win_en unchanged.
- R8: One cycle after bus_addr is presented, hit is 1 exactly when win_en is 1 and win_base <= bus_addr < win_base + 2^win_size_log2. When hit is 1, hit_off equals bus_addr - win_base.
- R9: cell_idx equals hit_off shifted right by 7 plus the grain, where the grain is written through cfg_wdata[2:0] with cfg_sel=3. cell_oor is 1 exactly when cell_idx is at least the cell count.
- R10: A read strobe loads cfg_rdata with the addressed register, and the value is visible in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_sel | input | 2 | Register select: 0 index, 1 entry low, 2 entry high, 3 control |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Registered read data |
| win_base | output | 52 | Window base address from entry 0 |
| win_size_log2 | output | 5 | Window size exponent from entry 0 |
| win_en | output | 1 | Window enable from entry 0 |
| bus_addr | input | 52 | Address to decode |
| hit | output | 1 | Address lies inside the enabled window |
| hit_off | output | 52 | Address minus window base |
| cell_idx | output | 52 | Offset divided by the cell stride |
| cell_oor | output | 1 | Cell index is at or beyond the cell count |

## Verification
A corrupted entry 0 shows up on win_base, win_size_log2 or win_en one cycle after the write that caused it. On the next decoded address it also shows up as a wrong hit or a wrong offset. A wrong index or a bad mask is hidden until an entry is read back, so the bench reads back after every masked write and after every write with an out-of-range index. A wrong grain or cell count shows only as a cell_idx or cell_oor error on addresses whose offset sits on either side of the last cell, so the address table includes those offsets.

// File: rtl/awb_pkg.sv
package awb_pkg;
  localparam int ENT_W      = 64;
  localparam int IDX_W      = 6;
  localparam int BASE_LSB   = 13;
  localparam int BASE_MSB   = 47;
  localparam int BASE_SHIFT = 4;
  localparam int ADDR_W     = BASE_MSB + 1 + BASE_SHIFT;
  localparam int LOG2_W     = 5;
  localparam int STRIDE_MIN = 7;
  localparam int CNT_LSB    = 8;
  localparam int HALF_W     = 32;
  localparam logic [ENT_W-1:0] LOW_MASK  = 64'h0000_0FFF_FFFF_F03F;
  localparam logic [ENT_W-1:0] HIGH_MASK = 64'h0000_0FFF_0000_0000;
  localparam logic [ENT_W-1:0] ENT0_RST  = 64'h0000_0000_0000_0022;

  typedef enum logic [1:0] {
    SEL_IDX = 2'd0,
    SEL_LO  = 2'd1,
    SEL_HI  = 2'd2,
    SEL_CTL = 2'd3
  } awb_sel_e;
endpackage

// File: rtl/awb_regfile.sv
module awb_regfile
  import awb_pkg::*;
#(
  parameter int NUM_ENT   = 2,
  parameter int GRAIN_W   = 3,
  parameter int CNT_W     = 8,
  parameter int NUM_CELLS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               rd,
  input  logic [1:0]         sel,
  input  logic [ENT_W-1:0]   wdata,
  output logic [ENT_W-1:0]   rdata,
  output logic [ENT_W-1:0]   ent0,
  output logic [GRAIN_W-1:0] grain,
  output logic [CNT_W-1:0]   count
);
  localparam int SUB_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  awb_sel_e           sel_e;
  logic [IDX_W-1:0]   idx_q;
  logic [ENT_W-1:0]   ent_q [NUM_ENT];
  logic [SUB_W-1:0]   sub;
  logic               idx_ok;
  logic [ENT_W-1:0]   cur;
  logic [ENT_W-1:0]   ctl_word;

  assign sel_e    = awb_sel_e'(sel);
  assign idx_ok   = (idx_q < IDX_W'(NUM_ENT));
  assign sub      = idx_q[SUB_W-1:0];
  assign cur      = idx_ok ? ent_q[sub] : '0;
  assign ctl_word = (ENT_W'(count) << CNT_LSB) | ENT_W'(grain);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        ent_q[i] <= (i == 0) ? ENT0_RST : '0;
      end
      grain <= '0;
      count <= CNT_W'(NUM_CELLS);
      rdata <= '0;
    end else begin
      if (wr) begin
        case (sel_e)
          SEL_IDX: idx_q <= wdata[IDX_W-1:0];
          SEL_LO: if (idx_ok) ent_q[sub] <= wdata & LOW_MASK;
          SEL_HI: if (idx_ok) ent_q[sub] <= ((wdata << HALF_W) & HIGH_MASK)
                                           | (ent_q[sub] & {{HALF_W{1'b0}}, {HALF_W{1'b1}}});
          SEL_CTL: grain <= wdata[GRAIN_W-1:0];
          default: ;
        endcase
      end
      if (rd) begin
        case (sel_e)
          SEL_IDX: rdata <= ENT_W'(idx_q);
          SEL_LO,
          SEL_HI:  rdata <= cur;
          SEL_CTL: rdata <= ctl_word;
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign ent0 = ent_q[0];
endmodule

// File: rtl/awb_window.sv
module awb_window
  import awb_pkg::*;
(
  input  logic [ENT_W-1:0]  ent,
  output logic [ADDR_W-1:0] base,
  output logic [LOG2_W-1:0] size_log2,
  output logic              en
);
  logic unused_bits;

  assign base        = {ent[BASE_MSB:BASE_LSB], {(BASE_LSB + BASE_SHIFT){1'b0}}};
  assign size_log2   = ent[LOG2_W:1];
  assign en          = ent[0];
  assign unused_bits = ^{ent[ENT_W-1:BASE_MSB+1], ent[BASE_LSB-1:LOG2_W+1]};
endmodule

// File: rtl/awb_decode.sv
module awb_decode
  import awb_pkg::*;
#(
  parameter int GRAIN_W = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ADDR_W-1:0]  base,
  input  logic [LOG2_W-1:0]  size_log2,
  input  logic               en,
  input  logic [GRAIN_W-1:0] grain,
  input  logic [CNT_W-1:0]   count,
  output logic               hit,
  output logic [ADDR_W-1:0]  off,
  output logic [ADDR_W-1:0]  idx,
  output logic               oor
);
  localparam int SH_W = $clog2(ADDR_W);

  logic [ADDR_W-1:0] off_c;
  logic [ADDR_W-1:0] size_c;
  logic [ADDR_W-1:0] idx_c;
  logic [SH_W-1:0]   sh_c;
  logic              hit_c;

  always_comb begin
    off_c  = addr - base;
    size_c = ADDR_W'(1) << size_log2;
    hit_c  = en && (addr >= base) && (off_c < size_c);
    sh_c   = SH_W'(STRIDE_MIN) + SH_W'(grain);
    idx_c  = off_c >> sh_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
      off <= '0;
      idx <= '0;
      oor <= 1'b0;
    end else begin
      hit <= hit_c;
      off <= off_c;
      idx <= idx_c;
      oor <= (idx_c >= ADDR_W'(count));
    end
  end
endmodule

// File: rtl/addr_window_bank.sv
module addr_window_bank
  import awb_pkg::*;
#(
  parameter int NUM_ENT   = 2,
  parameter int GRAIN_W   = 3,
  parameter int CNT_W     = 8,
  parameter int NUM_CELLS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [1:0]        cfg_sel,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  output logic [51:0]       win_base,
  output logic [4:0]        win_size_log2,
  output logic              win_en,
  input  logic [51:0]       bus_addr,
  output logic              hit,
  output logic [51:0]       hit_off,
  output logic [51:0]       cell_idx,
  output logic              cell_oor
);
  logic [ENT_W-1:0]   ent0_w;
  logic [GRAIN_W-1:0] grain_w;
  logic [CNT_W-1:0]   count_w;

  awb_regfile #(
    .NUM_ENT(NUM_ENT), .GRAIN_W(GRAIN_W), .CNT_W(CNT_W), .NUM_CELLS(NUM_CELLS)
  ) i_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ent0(ent0_w),
    .grain(grain_w), .count(count_w)
  );

  awb_window i_win (
    .ent(ent0_w), .base(win_base), .size_log2(win_size_log2), .en(win_en)
  );

  awb_decode #(.GRAIN_W(GRAIN_W), .CNT_W(CNT_W)) i_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .base(win_base),
    .size_log2(win_size_log2), .en(win_en), .grain(grain_w), .count(count_w),
    .hit(hit), .off(hit_off), .idx(cell_idx), .oor(cell_oor)
  );
endmodule

// File: rtl/awb_checker.sv
module awb_checker
  import awb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [1:0]        cfg_sel,
  input logic [ENT_W-1:0]  ent0,
  input logic [ADDR_W-1:0] win_base,
  input logic [LOG2_W-1:0] win_size_log2,
  input logic              win_en,
  input logic              hit,
  input logic [ADDR_W-1:0] hit_off
);
  AST_MASKED_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ent0 & ~LOW_MASK) == '0); // R3

  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel == 2'd2) |=> (ent0[31:0] == $past(ent0[31:0]))); // R4

  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && (cfg_sel == 2'd1 || cfg_sel == 2'd2))
      |=> ($stable(win_base) && $stable(win_size_log2) && $stable(win_en))); // R7

  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(win_en)); // R8

  AST_OFF_IN_SIZE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_off < (ADDR_W'(1) << $past(win_size_log2)))); // R8
endmodule

bind addr_window_bank awb_checker i_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .ent0(ent0_w),
  .win_base(win_base), .win_size_log2(win_size_log2), .win_en(win_en),
  .hit(hit), .hit_off(hit_off)
);

// File: tb/test_addr_window_bank.sv
module test_addr_window_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic [51:0] win_base;
  logic [4:0]  win_size_log2;
  logic        win_en;
  logic [51:0] bus_addr = '0;
  logic        hit;
  logic [51:0] hit_off;
  logic [51:0] cell_idx;
  logic        cell_oor;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  addr_window_bank i_addr_window_bank (.*);

  localparam int NV = 6;
  localparam logic [51:0] V_ADDR [NV] = '{52'h3F_FFFF, 52'h40_0000, 52'h40_07FF,
                                          52'h40_0800, 52'h40_0FFF, 52'h40_1000};
  localparam logic        V_HIT  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [51:0] V_OFF  [NV] = '{52'h0, 52'h0, 52'h7FF, 52'h800, 52'hFFF, 52'h0};
  localparam logic [51:0] V_IDX  [NV] = '{52'd0, 52'd0, 52'd15, 52'd16, 52'd31, 52'd0};
  localparam logic        V_OOR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [63:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_sel = s;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic probe(logic [51:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 hit", {63'b0, hit}, 64'h0);
    chk("R1 win_en", {63'b0, win_en}, 64'h0);
    chk("R1 size_log2", {59'b0, win_size_log2}, 64'd17);
    chk("R1 base", {12'b0, win_base}, 64'h0);
    rd(2'd0, d); chk("R1 index", d, 64'h0);
    rd(2'd1, d); chk("R1 entry0", d, 64'h22);
    rd(2'd3, d); chk("R1 ctrl", d, 64'h1000);
    // R10 read latency
    chk("R10 rdata held", cfg_rdata, 64'h1000);

    // R2 index keeps low 6 bits
    wr(2'd0, 64'h145); rd(2'd0, d); chk("R2 index", d, 64'h05);
    // R5 out-of-range index
    rd(2'd1, d); chk("R5 read zero", d, 64'h0);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(2'd2, 64'hFFF);
    wr(2'd0, 64'h0); rd(2'd1, d); chk("R5 entry0 kept", d, 64'h22);
    wr(2'd0, 64'h1); rd(2'd2, d); chk("R5 entry1 kept", d, 64'h0);

    // R3 low mask on entry 1
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, d); chk("R3 low mask", d, 64'h0000_0FFF_FFFF_F03F);
    // R7 entry 1 leaves window alone
    chk("R7 en", {63'b0, win_en}, 64'h0);
    chk("R7 log2", {59'b0, win_size_log2}, 64'd17);
    chk("R7 base", {12'b0, win_base}, 64'h0);
    // R4 high write
    wr(2'd2, 64'hFFFF_F5A5);
    rd(2'd2, d); chk("R4 high", d, 64'h0000_05A5_FFFF_F03F);

    // R6 program entry 0: base 0x400000, size 2^12, enabled
    wr(2'd0, 64'h0);
    wr(2'd1, 64'h4_0019);
    chk("R6 base", {12'b0, win_base}, 64'h40_0000);
    chk("R6 log2", {59'b0, win_size_log2}, 64'd12);
    chk("R6 en", {63'b0, win_en}, 64'h1);

    // R8 R9 table walk, grain 0 -> stride 128
    for (int i = 0; i < NV; i++) begin
      probe(V_ADDR[i]);
      chk("R8 hit", {63'b0, hit}, {63'b0, V_HIT[i]});
      if (V_HIT[i]) begin
        chk("R8 off", {12'b0, hit_off}, {12'b0, V_OFF[i]});
        chk("R9 idx", {12'b0, cell_idx}, {12'b0, V_IDX[i]});
        chk("R9 oor", {63'b0, cell_oor}, {63'b0, V_OOR[i]});
      end
    end

    // R9 grain 2 -> stride 512
    wr(2'd3, 64'h2);
    rd(2'd3, d); chk("R9 ctrl grain", d, 64'h1002);
    probe(52'h40_0E00);
    chk("R9 idx g2", {12'b0, cell_idx}, 64'd7);
    chk("R9 oor g2", {63'b0, cell_oor}, 64'h0);

    // R4 R6 high write to entry 0 moves the base live
    wr(2'd2, 64'h1);
    chk("R6 base hi", {12'b0, win_base}, 64'h10_0040_0000);
    rd(2'd1, d); chk("R4 entry0", d, 64'h0000_0001_0004_0019);
    probe(52'h40_0000);
    chk("R8 moved miss", {63'b0, hit}, 64'h0);

    // R8 disabled window never hits
    wr(2'd1, 64'h4_0018);
    probe(52'h40_0000);
    chk("R8 disabled", {63'b0, hit}, 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule